// File: doc/BRIEF.md
# Dual-bank interrupt controller

This block gathers 32 interrupt source lines and presents them to a processor through two independent banks: a normal bank and a fast bank. Both banks watch the same sources. Each bank has its own trigger-mode, polarity and enable settings, so a source can be routed to one bank, to both banks or to neither.

A source in edge mode latches a sticky pending bit when it becomes active. Software removes that bit by writing a one to the bank's clear register. A source in level mode is pending for as long as its polarity-corrected input is active.

Each bank drives one active-high request. The request is a registered level that stays high while any enabled source of that bank is pending. It can therefore feed one source input of another controller of the same kind, with that input set to level mode and active-high. Software reaches the registers through a simple word-addressed read and write port.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset every mode, polarity and enable register of both banks reads 0, and both requests are low.
- R2: A source in level mode (mode bit 0) with polarity bit 0 is pending exactly while its input is high. Its raw status bit follows the input, and the bank request follows it when the source is enabled.
- R3: Polarity bit 1 makes a source active-low. With polarity 1, a low input is pending and a high input is not.
- R4: A source in edge mode (mode bit 1) sets a sticky pending bit on its inactive-to-active transition. The bit stays set after the input returns inactive. A held-active input or a falling transition does not set it again.
- R5: Writing to a clear register clears the edge pending bits whose data bit is 1 and leaves the other bits unchanged. On a level-mode source a clear has no lasting effect.
- R6: If a new edge and a clear of the same source fall in the same cycle, the source stays pending.
- R7: The masked status equals raw status AND enable. A pending source with enable bit 0 shows in raw status, is 0 in masked status and does not raise the request.
- R8: The two banks share sources but not settings. Configuring or clearing one bank does not change the other bank's registers, status or request.
- R9: Address map (word addresses): addr[3] selects the bank (0 normal, 1 fast). addr[2:0] selects the register: 0 mode, 1 polarity, 2 enable, 3 clear (write-only, reads 0), 4 raw status, 5 masked status (both read-only). Codes 6 and 7 read 0, and writes to read-only codes are ignored.
- R10: Read data is registered. It appears in the cycle after the cycle in which rd_en_i is high, and it is 0 in every other cycle.
- R11: Each request is the OR of its bank's masked status, registered for one cycle. A level source change on src_i reaches the request after three rising edges (two synchroniser stages plus the request register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt source lines, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Word address: bank select and register code |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the read strobe |
| irq_norm_o | output | 1 | Normal bank request, active high |
| irq_fast_o | output | 1 | Fast bank request, active high |

## Verification
Two functions can land on the same rising edge: a clear write for a source, and the sticky-set caused by a fresh edge on that same source. The bench raises the source and lines up the clear strobe with the edge that latches the synchronised transition. At that edge the pending bit must survive. A second run places the clear one edge later, and there the bit must be gone. Both outcomes are judged through the raw status read of the fast bank.

// File: rtl/dic_pkg.sv
package dic_pkg;

    localparam int NBANK  = 2;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        RG_MODE = 3'd0,
        RG_POL  = 3'd1,
        RG_EN   = 3'd2,
        RG_CLR  = 3'd3,
        RG_RAW  = 3'd4,
        RG_MSK  = 3'd5
    } reg_sel_e;

endpackage

// File: rtl/dic_sync.sv
module dic_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d        = sy_q;
        sy_d.stage1 = async_i;
        sy_d.stage2 = sy_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign sync_o = sy_q.stage2;

endmodule

// File: rtl/dic_bank.sv
module dic_bank
    import dic_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            wr_i,
    input  reg_sel_e        sel_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] rd_o,
    output logic [NSRC-1:0] raw_o,
    output logic [NSRC-1:0] masked_o,
    output logic [NSRC-1:0] mode_o,
    output logic            irq_o
);

    typedef struct packed {
        logic [NSRC-1:0] mode;
        logic [NSRC-1:0] pol;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] prev;
        logic            irq;
    } bank_t;

    bank_t st_d, st_q;

    logic [NSRC-1:0] act;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] clr;
    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] masked;

    always_comb begin
        st_d = st_q;
        clr  = '0;

        // polarity correction and edge detection
        act  = src_i ^ st_q.pol;
        rise = act & ~st_q.prev;

        // register writes
        if (wr_i) begin
            case (sel_i)
                RG_MODE: st_d.mode = wdata_i;
                RG_POL:  st_d.pol  = wdata_i;
                RG_EN:   st_d.en   = wdata_i;
                RG_CLR:  clr       = wdata_i;
                default: ;
            endcase
        end

        // status: edge sources use the sticky bit, level sources the input
        raw    = (st_q.mode & st_q.pend) | (~st_q.mode & act);
        masked = raw & st_q.en;

        // a fresh edge overrides a clear in the same cycle
        st_d.prev = act;
        st_d.pend = ((st_q.pend & ~clr) | rise) & st_q.mode;
        st_d.irq  = |masked;

        // read mux
        case (sel_i)
            RG_MODE: rd_o = st_q.mode;
            RG_POL:  rd_o = st_q.pol;
            RG_EN:   rd_o = st_q.en;
            RG_RAW:  rd_o = raw;
            RG_MSK:  rd_o = masked;
            default: rd_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o    = raw;
    assign masked_o = masked;
    assign mode_o   = st_q.mode;
    assign irq_o    = st_q.irq;

endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
    import dic_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NSRC-1:0]   wdata_i,
    output logic [NSRC-1:0]   rdata_o,
    output logic              irq_norm_o,
    output logic              irq_fast_o
);

    localparam int BANK_BIT = ADDR_W - 1;

    typedef struct packed {
        logic [NSRC-1:0] rdata;
    } top_t;

    top_t tp_d, tp_q;

    logic [NSRC-1:0]  src_sync;
    reg_sel_e         sel;
    logic [NSRC-1:0]  bank_rd     [NBANK];
    logic [NSRC-1:0]  bank_raw    [NBANK];
    logic [NSRC-1:0]  bank_masked [NBANK];
    logic [NSRC-1:0]  bank_mode   [NBANK];
    logic [NBANK-1:0] bank_irq;

    assign sel = reg_sel_e'(addr_i[SEL_W-1:0]);

    dic_sync #(.W(NSRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (src_sync)
    );

    for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
        logic bank_wr;
        assign bank_wr = wr_en_i && (int'(addr_i[BANK_BIT]) == gb);

        dic_bank #(.NSRC(NSRC)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_i    (src_sync),
            .wr_i     (bank_wr),
            .sel_i    (sel),
            .wdata_i  (wdata_i),
            .rd_o     (bank_rd[gb]),
            .raw_o    (bank_raw[gb]),
            .masked_o (bank_masked[gb]),
            .mode_o   (bank_mode[gb]),
            .irq_o    (bank_irq[gb])
        );
    end

    always_comb begin
        tp_d = tp_q;
        if (rd_en_i) tp_d.rdata = bank_rd[addr_i[BANK_BIT]];
        else         tp_d.rdata = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tp_q <= '0;
        else        tp_q <= tp_d;
    end

    assign rdata_o    = tp_q.rdata;
    assign irq_norm_o = bank_irq[0];
    assign irq_fast_o = bank_irq[1];

endmodule

// File: rtl/dic_chk.sv
module dic_chk #(
    parameter int NSRC   = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [NSRC-1:0]   rdata_o,
    input logic              irq_norm_o,
    input logic              irq_fast_o,
    input logic [NSRC-1:0]   raw_n,
    input logic [NSRC-1:0]   msk_n,
    input logic [NSRC-1:0]   mode_n,
    input logic [NSRC-1:0]   msk_f
);

    // R11
    irq_norm_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_norm_o == (|$past(msk_n)));

    // R11
    irq_fast_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast_o == (|$past(msk_f)));

    // R10
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en_i) |-> rdata_o == '0);

    // R9
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en_i && addr_i[ADDR_W-2:0] == 3'd3) |-> rdata_o == '0);

    // R4
    edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en_i) |-> (($past(raw_n) & $past(mode_n)) & ~raw_n) == '0);

    // R8
    bank_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en_i && addr_i[ADDR_W-1]) |-> $stable(mode_n));

endmodule

bind dual_irq_ctrl dic_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .rdata_o    (rdata_o),
    .irq_norm_o (irq_norm_o),
    .irq_fast_o (irq_fast_o),
    .raw_n      (bank_raw[0]),
    .msk_n      (bank_masked[0]),
    .mode_n     (bank_mode[0]),
    .msk_f      (bank_masked[1])
);

// File: tb/dual_irq_ctrl_bench.sv
`timescale 1ns/100ps
module dual_irq_ctrl_bench;

    localparam int NSRC = 32;
    localparam int AW   = 4;

    // register codes (R9)
    localparam logic [2:0] C_MODE = 3'd0, C_POL = 3'd1, C_EN = 3'd2,
                           C_CLR = 3'd3, C_RAW = 3'd4, C_MSK = 3'd5;
    localparam logic NB = 1'b0, FB = 1'b1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [NSRC-1:0] wdata = '0;
    logic [NSRC-1:0] rdata;
    logic            irq_n, irq_f;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [NSRC-1:0] exp;
        string           tag;
    } item_t;

    item_t sb[$];

    always #2.5 clk = ~clk;

    dual_irq_ctrl u_dual_irq_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src),
        .wr_en_i    (wr_en),
        .rd_en_i    (rd_en),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .irq_norm_o (irq_n),
        .irq_fast_o (irq_f)
    );

    task automatic chk(input logic [NSRC-1:0] act, input logic [NSRC-1:0] exp,
                       input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic bank, input logic [2:0] code,
                      input logic [NSRC-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = {bank, code}; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // driver: issues a read and pushes the expected word
    task automatic rd(input logic bank, input logic [2:0] code,
                      input logic [NSRC-1:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.tag = tag;
        @(negedge clk);
        rd_en = 1'b1; addr = {bank, code};
        sb.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic set_src(input logic [NSRC-1:0] v);
        @(negedge clk);
        src = v;
    endtask

    // monitor: compares read data one cycle after the strobe
    always @(posedge clk) begin
        if (rd_en) begin
            #1;
            if (sb.size() == 0) begin
                chk(rdata, '0, "R10 unexpected read");
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(rdata, it.exp, it.tag);
            end
        end
    end

    bit finished = 1'b0;

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(irq_n, 1'b0, "R1 irq_norm after reset");
        chk(irq_f, 1'b0, "R1 irq_fast after reset");
        chk(rdata, '0, "R10 idle read data");
        rd(NB, C_MODE, '0, "R1 mode normal");
        rd(NB, C_POL,  '0, "R1 polarity normal");
        rd(NB, C_EN,   '0, "R1 enable normal");
        rd(FB, C_MODE, '0, "R1 mode fast");
        rd(FB, C_EN,   '0, "R1 enable fast");

        // R2 / R11 level source, exact latency
        wr(NB, C_EN, 32'h1);
        @(negedge clk); src = 32'h1;
        @(negedge clk); @(negedge clk);
        chk(irq_n, 1'b0, "R11 request not before third edge");
        @(negedge clk);
        chk(irq_n, 1'b1, "R11 request at third edge");
        chk(irq_f, 1'b0, "R8 fast bank unaffected");
        rd(NB, C_RAW, 32'h1, "R2 raw normal");
        rd(NB, C_MSK, 32'h1, "R7 masked normal");
        rd(FB, C_RAW, 32'h1, "R8 shared source raw fast");
        rd(FB, C_MSK, 32'h0, "R8 masked fast");

        // R5 clear on a level source has no lasting effect
        wr(NB, C_CLR, 32'h1);
        settle();
        chk(irq_n, 1'b1, "R5 level request after clear");
        rd(NB, C_RAW, 32'h1, "R5 level raw after clear");

        // R2 deassert
        set_src(32'h0);
        settle();
        chk(irq_n, 1'b0, "R2 request drops with input");
        rd(NB, C_RAW, 32'h0, "R2 raw follows input");

        // R3 active-low
        wr(NB, C_POL, 32'h2);
        wr(NB, C_EN, 32'h2);
        settle();
        chk(irq_n, 1'b1, "R3 low input active");
        rd(NB, C_RAW, 32'h2, "R3 raw active-low");
        set_src(32'h2);
        settle();
        chk(irq_n, 1'b0, "R3 high input inactive");
        rd(NB, C_RAW, 32'h0, "R3 raw inactive");
        set_src(32'h0);
        wr(NB, C_POL, 32'h0);
        wr(NB, C_EN, 32'h0);

        // R4 edge mode on fast bank
        wr(FB, C_MODE, 32'h4);
        wr(FB, C_EN, 32'h4);
        set_src(32'h4);
        settle();
        set_src(32'h0);
        settle();
        chk(irq_f, 1'b1, "R4 sticky fast request");
        rd(FB, C_RAW, 32'h4, "R4 sticky raw fast");
        rd(NB, C_RAW, 32'h0, "R4 level bank sees low input");
        wr(FB, C_CLR, 32'h4);
        settle();
        chk(irq_f, 1'b0, "R5 request gone after clear");
        rd(FB, C_RAW, 32'h0, "R5 raw gone after clear");
        set_src(32'h4);
        settle();
        rd(FB, C_RAW, 32'h4, "R4 new rising edge");
        wr(FB, C_CLR, 32'h4);
        settle();
        rd(FB, C_RAW, 32'h0, "R4 held input does not re-set");
        set_src(32'h0);
        settle();
        rd(FB, C_RAW, 32'h0, "R4 falling edge does not set");

        // R5 selective clear
        wr(FB, C_MODE, 32'hC);
        wr(FB, C_EN, 32'hC);
        set_src(32'hC);
        settle();
        set_src(32'h0);
        settle();
        rd(FB, C_RAW, 32'hC, "R5 two edges latched");
        wr(FB, C_CLR, 32'h4);
        rd(FB, C_RAW, 32'h8, "R5 only written bit cleared");
        rd(FB, C_MSK, 32'h8, "R7 masked after partial clear");
        wr(FB, C_CLR, 32'h8);
        rd(FB, C_RAW, 32'h0, "R5 second clear");

        // R6 clear in the same cycle as a new edge
        @(negedge clk); src = 32'h8;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; addr = {FB, C_CLR}; wdata = 32'h8;
        @(negedge clk); wr_en = 1'b0;
        settle();
        rd(FB, C_RAW, 32'h8, "R6 edge wins over clear");
        set_src(32'h0);
        wr(FB, C_CLR, 32'h8);
        settle();
        // clear one edge later removes it
        @(negedge clk); src = 32'h8;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; addr = {FB, C_CLR}; wdata = 32'h8;
        @(negedge clk); wr_en = 1'b0;
        settle();
        rd(FB, C_RAW, 32'h0, "R6 later clear removes edge");
        set_src(32'h0);
        settle();

        // R9 map corners
        rd(FB, C_CLR, '0, "R9 clear reads zero");
        wr(NB, C_RAW, 32'hFFFF_FFFF);
        wr(NB, C_MSK, 32'hFFFF_FFFF);
        rd(NB, C_MODE, '0, "R9 status write ignored mode");
        rd(NB, C_EN, '0, "R9 status write ignored enable");
        rd(NB, 3'd6, '0, "R9 unused code reads zero");
        rd(FB, C_MODE, 32'hC, "R8 fast mode kept");

        // R7 disabled source
        set_src(32'h1);
        settle();
        chk(irq_n, 1'b0, "R7 disabled source no request");
        rd(NB, C_RAW, 32'h1, "R7 raw shows disabled source");
        rd(NB, C_MSK, 32'h0, "R7 masked hides disabled source");
        set_src(32'h0);

        repeat (4) @(negedge clk);
        chk(sb.size(), 0, "R10 all reads answered");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule